// File: doc/BRIEF.md
# Sensor-Driven Two-Road Traffic Controller

This block drives the lamps of a crossing where two roads, A and B, meet. Each road has a traffic sensor (`sense_a`, `sense_b`, synchronous to `clk`) and a 2-bit lamp code. The controller is a Moore machine with four named phases:

- `PH_A_GO` (code 00): A green, B red.
- `PH_A_WARN` (code 01): A yellow, B red.
- `PH_B_GO` (code 10): A red, B green.
- `PH_B_WARN` (code 11): A red, B yellow.

Road A keeps its green for as long as its sensor reports traffic. Once A is empty the controller passes through A-yellow and hands the green to B, which keeps it while B has traffic, and then returns through B-yellow. The transitions are:

- T_A_HOLD: `PH_A_GO` to `PH_A_GO` while `sense_a`=1.
- T_A_RELEASE: `PH_A_GO` to `PH_A_WARN` when `sense_a`=0.
- T_A_CLEAR: `PH_A_WARN` to `PH_B_GO` unconditionally.
- T_B_HOLD: `PH_B_GO` to `PH_B_GO` while `sense_b`=1.
- T_B_RELEASE: `PH_B_GO` to `PH_B_WARN` when `sense_b`=0.
- T_B_CLEAR: `PH_B_WARN` to `PH_A_GO` unconditionally.

The parameter `MIN_DWELL` gates every transition. Each phase must last at least that many cycles before the controller may leave it. With 0 or 1, a decision is made on every clock.

The phase codes make the next-state and lamp logic reduce to small equations. The upper next-state bit is the XOR of the two state bits. The lamp codes come straight from the state bits.

Top module: `crossing_light_ctrl`

## Requirements
- R1: `rst` is asynchronous and active-high. While it is high, the block is in `PH_A_GO` with `lamp_a`=00 (green) and `lamp_b`=10 (red), without waiting for a clock edge.
- R2: In `PH_A_GO`, a clock edge with `sense_a`=1 keeps the phase. A clock edge with `sense_a`=0 moves to `PH_A_WARN` (`lamp_a`=01 yellow, `lamp_b`=10 red). `sense_b` has no effect in this phase.
- R3: `PH_A_WARN` moves to `PH_B_GO` (`lamp_a`=10 red, `lamp_b`=00 green) whatever the sensors are.
- R4: In `PH_B_GO`, a clock edge with `sense_b`=1 keeps the phase. A clock edge with `sense_b`=0 moves to `PH_B_WARN` (`lamp_a`=10 red, `lamp_b`=01 yellow). `sense_a` has no effect in this phase.
- R5: `PH_B_WARN` moves to `PH_A_GO` whatever the sensors are.
- R6: The lamp codes are green=00, yellow=01 and red=10, and 11 never appears. In every cycle at least one road shows red.
- R7: When `MIN_DWELL`=N>1, no transition happens before the phase has been held for N cycles. After that, the transition is taken at the first clock edge whose sensor condition allows it. The two yellow phases therefore last exactly N cycles.
- R8: When `MIN_DWELL` is 0 or 1, the transitions of R2 to R5 are evaluated on every clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| sense_a | input | 1 | Traffic present on road A |
| sense_b | input | 1 | Traffic present on road B |
| lamp_a | output | 2 | Road A lamp code (00 green, 01 yellow, 10 red) |
| lamp_b | output | 2 | Road B lamp code (00 green, 01 yellow, 10 red) |

## Verification
The hardest case to reach is a sensor that changes exactly on the cycle the dwell window closes, in an instance with `MIN_DWELL`=4. If the sensor falls one cycle early it must be ignored; if it falls on the closing cycle it must be acted on. Random stimulus with long biased runs seldom lines up with that boundary. A directed stretch that toggles both sensors on every cycle therefore sweeps every alignment against the window. The same stimulus also runs against instances with `MIN_DWELL` of 0 and 1, and a bench model predicts the lamps of all three.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_t;

    typedef enum logic [1:0] {
        LAMP_GREEN  = 2'b00,
        LAMP_YELLOW = 2'b01,
        LAMP_RED    = 2'b10
    } lamp_t;

endpackage

// File: rtl/tlc_dwell_timer.sv
module tlc_dwell_timer #(
    parameter int MIN_DWELL = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_change,
    output logic dwell_ok
);
    localparam int CW = (MIN_DWELL < 2) ? 1 : $clog2(MIN_DWELL);
    localparam logic [CW-1:0] SAT = (MIN_DWELL < 2) ? '0 : CW'(MIN_DWELL - 1);

    logic [CW-1:0] held_q;

    // Counts cycles spent in the current phase and saturates once the window is met.
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            held_q <= '0;
        else if (phase_change)
            held_q <= '0;
        else if (held_q != SAT)
            held_q <= held_q + 1'b1;
    end

    assign dwell_ok = (MIN_DWELL < 2) ? 1'b1 : (held_q == SAT);

endmodule

// File: rtl/tlc_next_phase.sv
module tlc_next_phase
    import tlc_pkg::*;
(
    input  phase_t cur,
    input  logic   sense_a,
    input  logic   sense_b,
    input  logic   dwell_ok,
    output phase_t nxt
);
    always_comb begin
        nxt = cur;
        if (dwell_ok) begin
            unique case (cur)
                PH_A_GO:   nxt = sense_a ? PH_A_GO : PH_A_WARN;
                PH_A_WARN: nxt = PH_B_GO;
                PH_B_GO:   nxt = sense_b ? PH_B_GO : PH_B_WARN;
                PH_B_WARN: nxt = PH_A_GO;
                default:   nxt = PH_A_GO;
            endcase
        end
    end
endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
(
    input  phase_t     cur,
    output logic [1:0] lamp_a,
    output logic [1:0] lamp_b
);
    always_comb begin
        lamp_a = LAMP_RED;
        lamp_b = LAMP_RED;
        unique case (cur)
            PH_A_GO:   begin lamp_a = LAMP_GREEN;  lamp_b = LAMP_RED;    end
            PH_A_WARN: begin lamp_a = LAMP_YELLOW; lamp_b = LAMP_RED;    end
            PH_B_GO:   begin lamp_a = LAMP_RED;    lamp_b = LAMP_GREEN;  end
            PH_B_WARN: begin lamp_a = LAMP_RED;    lamp_b = LAMP_YELLOW; end
            default:   begin lamp_a = LAMP_RED;    lamp_b = LAMP_RED;    end
        endcase
    end
endmodule

// File: rtl/crossing_light_ctrl.sv
module crossing_light_ctrl
    import tlc_pkg::*;
#(
    parameter int MIN_DWELL = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sense_a,
    input  logic       sense_b,
    output logic [1:0] lamp_a,
    output logic [1:0] lamp_b
);
    phase_t phase_q;
    phase_t phase_d;
    logic   dwell_ok;

    tlc_dwell_timer #(.MIN_DWELL(MIN_DWELL)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .phase_change (phase_d != phase_q),
        .dwell_ok     (dwell_ok)
    );

    tlc_next_phase u_next (
        .cur      (phase_q),
        .sense_a  (sense_a),
        .sense_b  (sense_b),
        .dwell_ok (dwell_ok),
        .nxt      (phase_d)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) phase_q <= PH_A_GO;
        else     phase_q <= phase_d;
    end

    tlc_lamp_decode u_lamps (
        .cur    (phase_q),
        .lamp_a (lamp_a),
        .lamp_b (lamp_b)
    );

    a_r2_hold_a: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_A_GO && sense_a) |=> (phase_q == PH_A_GO));

    a_r4_hold_b: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_B_GO && sense_b) |=> (phase_q == PH_B_GO));

    a_r3_warn_a_exit: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_A_WARN) |=> (phase_q == PH_A_WARN || phase_q == PH_B_GO));

    a_r5_warn_b_exit: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_B_WARN) |=> (phase_q == PH_B_WARN || phase_q == PH_A_GO));

    a_r6_one_red: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == LAMP_RED) || (lamp_b == LAMP_RED));

    a_r7_dwell_hold: assert property (@(posedge clk) disable iff (rst)
        !dwell_ok |=> $stable(phase_q));

endmodule

// File: tb/tb_crossing_light_ctrl.sv
module tb_crossing_light_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sa = 1'b0;
    logic sb = 1'b0;
    always #5 clk = ~clk;

    localparam int ND = 3;
    localparam int DW [ND] = '{0, 1, 4};

    logic [1:0] la [ND];
    logic [1:0] lb [ND];

    crossing_light_ctrl #(.MIN_DWELL(0)) dut (
        .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb), .lamp_a(la[0]), .lamp_b(lb[0]));
    crossing_light_ctrl #(.MIN_DWELL(1)) dut1 (
        .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb), .lamp_a(la[1]), .lamp_b(lb[1]));
    crossing_light_ctrl #(.MIN_DWELL(4)) dut4 (
        .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb), .lamp_a(la[2]), .lamp_b(lb[2]));

    int errors = 0;
    int checks = 0;
    int m_st  [ND];
    int m_cnt [ND];

    function automatic int model_next(int s, logic ta, logic tb, int cnt, int n);
        if (!(n <= 1 || cnt >= n - 1)) return s;
        case (s)
            0: return ta ? 0 : 1;
            1: return 2;
            2: return tb ? 2 : 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] model_lamps(int s);
        case (s)
            0: return 4'b00_10;
            1: return 4'b01_10;
            2: return 4'b10_00;
            default: return 4'b10_01;
        endcase
    endfunction

    function automatic string req_of(int i, int s);
        if (i == 2) return "R7";
        if (i == 0) return "R8";
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_lamps(string req);
        for (int i = 0; i < ND; i++) begin
            logic [3:0] exp_l;
            exp_l = model_lamps(m_st[i]);
            checks++;
            if ({la[i], lb[i]} !== exp_l) begin
                errors++;
                $display("FAIL %s inst%0d: lamps a=%b b=%b, expected a=%b b=%b",
                         (req == "") ? req_of(i, m_st[i]) : req, i, la[i], lb[i],
                         exp_l[3:2], exp_l[1:0]);
            end
            checks++;
            if (la[i] === 2'b11 || lb[i] === 2'b11 || (la[i] !== 2'b10 && lb[i] !== 2'b10)) begin
                errors++;
                $display("FAIL R6 inst%0d: lamps a=%b b=%b, expected legal codes with one red",
                         i, la[i], lb[i]);
            end
        end
    endtask

    task automatic advance();
        for (int i = 0; i < ND; i++) begin
            int n;
            n = model_next(m_st[i], sa, sb, m_cnt[i], DW[i]);
            if (n != m_st[i]) m_cnt[i] = 0;
            else if (m_cnt[i] < DW[i]) m_cnt[i]++;
            m_st[i] = n;
        end
    endtask

    task automatic step(logic ta, logic tb);
        @(negedge clk);
        check_lamps("");
        sa = ta;
        sb = tb;
        advance();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        #1;
        for (int i = 0; i < ND; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
        check_lamps("R1");
        @(negedge clk);
        check_lamps("R1");
        rst = 1'b0;
        advance();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R1 watchdog expired: actual hung, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < ND; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
        #1;
        check_lamps("R1");
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        advance();

        // R2: traffic on A keeps A green, B sensor ignored
        for (int k = 0; k < 20; k++) step(1'b1, k[0]);
        // R3 R4: A empties, B keeps its green while busy
        for (int k = 0; k < 20; k++) step(1'b0, 1'b1);
        // R5: B empties, cycle returns
        for (int k = 0; k < 12; k++) step(k[1], 1'b0);
        // R7: toggle both sensors every cycle against the dwell window
        for (int k = 0; k < 60; k++) step(k[0], ~k[0]);
        for (int k = 0; k < 60; k++) step(k[1], k[0]);
        do_reset();

        for (int blk = 0; blk < 30; blk++) begin
            int pa;
            int pb;
            pa = $urandom % 4;
            pb = $urandom % 4;
            for (int k = 0; k < 60; k++)
                step(($urandom % 4) < pa, ($urandom % 4) < pb);
            if (blk % 10 == 9) do_reset();
        end

        @(negedge clk);
        check_lamps("");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule